// File: doc/BRIEF.md
# Stereo Audio Serial Formatter

This block takes parallel stereo samples and shifts them out on a three-wire serial audio link: a word-select line, a bit clock and a data line. Each frame holds two channel slots, left then right. The slot length can be 16 or 32 bit clocks. A 5-bit delay value sets how many bit clocks pass between the start of a slot and the MSB of the sample placed in it. Standard I2S, MSB-justified and LSB-justified layouts all come from this one delay. Samples are 16 or 18 bits wide. A narrow sample sits in the low 16 bits of each input word.

Samples enter on a valid/ready stream. `s_ready` is high while the formatter is idle, and otherwise only in the system-clock cycle that closes a frame. A sample is taken when `s_valid` and `s_ready` are both high. A sample offered at any other time waits, and the source must hold it stable until `s_ready` rises. If no sample is waiting at a frame boundary, the current sample is sent again. The bit clock is made from a system-clock enable: each enabled cycle is one half period of the bit clock. The bit clock does not start until the first sample has been accepted.

Top module: `audio_serial_fmt`

## Requirements
- R1: With `slot_long`=0 each channel slot lasts 16 bit-clock periods, and with `slot_long`=1 it lasts 32. A frame is two slots.
- R2: `ws` is 0 during the left slot and 1 during the right slot. It changes only together with a falling edge of `bck`.
- R3: Slot bit k (counting from 0 at the slot's first falling edge) carries sample bit W-1-(k-D). D is `just_dly` taken modulo the slot length. W is 18 when `sample_wide`=1 and 16 otherwise. So D=1 gives I2S, D=0 gives MSB-justified, and with 32-bit slots D=16 (W=16) or D=14 (W=18) puts the LSB on the slot's last clock.
- R4: Every frame position that no channel window covers drives `sdo` low. Where the windows overlap, the left window wins.
- R5: `sdo` changes only together with a falling edge of `bck`. It is stable across each rising edge.
- R6: `bck` starts low and stays low until the first sample is accepted. After that, each cycle with `bclk_tick` high toggles `bck`, and no other cycle changes it.
- R7: `s_ready` is 1 while the formatter is idle. Once running, it is 1 only in a cycle with `bclk_tick` high, `bck` high and the frame at its last bit position. A sample is accepted only when `s_valid` and `s_ready` are both high.
- R8: If `s_valid` is low at a frame boundary, the next frame sends the same left and right samples again.
- R9: A window that runs past the end of the frame continues at position 0 of the next frame with the bits of the sample it started with. Before any sample exists, those bits are 0. In I2S with 16-bit slots, the right LSB therefore lands on the first clock of the next frame's left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | Half-period enable for the bit clock |
| slot_long | input | 1 | 0: 16-clock slots, 1: 32-clock slots |
| sample_wide | input | 1 | 0: 16-bit samples, 1: 18-bit samples |
| just_dly | input | 5 | Bit clocks from slot start to MSB |
| s_valid | input | 1 | Stereo sample offered |
| s_ready | output | 1 | Sample taken this cycle if valid |
| s_left | input | 18 | Left sample, right-aligned |
| s_right | input | 18 | Right sample, right-aligned |
| ws | output | 1 | Word select, 1 = right channel |
| bck | output | 1 | Bit clock |
| sdo | output | 1 | Serial data, MSB first |

## Verification
The serializer is run in six settings:
- I2S with 16-bit slots, which exercises the spill of the right LSB into the next frame.
- MSB-justified with 16-bit slots.
- 16-bit and 18-bit LSB-justified with 32-bit slots, which checks that the window end lands exactly on the slot end.
- I2S with wide samples and a slow bit-clock enable, given only a few samples, which separates repeat-on-starvation from stale or zero data.
- A delay larger than the slot length, with overlapping windows, which checks the modulo rule and left priority.

Each setting begins with an idle stretch that holds `s_valid` low, showing that the bit clock waits for the first sample. Back-pressure timing is compared on every cycle.

// File: rtl/afmt_pkg.sv
package afmt_pkg;
  localparam int SAMPLE_BITS = 18;
  localparam int NARROW_BITS = 16;
  localparam int SHORT_SLOT  = 16;
  localparam int LONG_SLOT   = 32;
  localparam int DELAY_BITS  = 5;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/afmt_timing.sv
module afmt_timing #(
  parameter int SLOT_S = 16,
  parameter int SLOT_L = 32,
  localparam int POS_W = $clog2(2 * SLOT_L)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             size_long,
  output logic             running,
  output logic             bck,
  output logic             fall_now,
  output logic             frame_end,
  output logic [POS_W-1:0] pos_nxt,
  output logic [POS_W-1:0] slot_len,
  output logic [POS_W-1:0] frame_mask
);
  logic             run_q, bck_q;
  logic [POS_W-1:0] pos_q;

  assign slot_len   = size_long ? POS_W'(SLOT_L) : POS_W'(SLOT_S);
  assign frame_mask = size_long ? POS_W'(2 * SLOT_L - 1) : POS_W'(2 * SLOT_S - 1);
  assign fall_now   = run_q & tick & bck_q;
  assign frame_end  = fall_now & (pos_q >= frame_mask);

  always_comb begin
    if (!run_q)         pos_nxt = '0;
    else if (frame_end) pos_nxt = '0;
    else if (fall_now)  pos_nxt = pos_q + 1'b1;
    else                pos_nxt = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      bck_q <= 1'b0;
      pos_q <= '0;
    end else if (!run_q) begin
      if (start) begin
        run_q <= 1'b1;
        bck_q <= 1'b0;
        pos_q <= '0;
      end
    end else if (tick) begin
      bck_q <= ~bck_q;
      pos_q <= pos_nxt;
    end
  end

  assign running = run_q;
  assign bck     = bck_q;
endmodule

// File: rtl/afmt_sample_hold.sv
module afmt_sample_hold #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         advance,
  input  logic [W-1:0] in_l,
  input  logic [W-1:0] in_r,
  output logic [W-1:0] cur_l_nxt,
  output logic [W-1:0] cur_r_nxt,
  output logic [W-1:0] old_l_nxt,
  output logic [W-1:0] old_r_nxt
);
  logic [W-1:0] cur_l, cur_r, old_l, old_r;

  assign cur_l_nxt = load ? in_l : cur_l;
  assign cur_r_nxt = load ? in_r : cur_r;
  assign old_l_nxt = (load | advance) ? cur_l : old_l;
  assign old_r_nxt = (load | advance) ? cur_r : old_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_l <= '0;
      cur_r <= '0;
      old_l <= '0;
      old_r <= '0;
    end else begin
      cur_l <= cur_l_nxt;
      cur_r <= cur_r_nxt;
      old_l <= old_l_nxt;
      old_r <= old_r_nxt;
    end
  end
endmodule

// File: rtl/afmt_win.sv
module afmt_win #(
  parameter int W     = 18,
  parameter int POS_W = 6,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] base,
  input  logic [POS_W-1:0] eff_dly,
  input  logic [POS_W-1:0] win_len,
  input  logic [POS_W-1:0] frame_mask,
  input  logic [W-1:0]     cur,
  input  logic [W-1:0]     old,
  output logic             hit,
  output logic             bit_o
);
  logic [POS_W-1:0] first, off;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     src;

  assign first = base + eff_dly;
  assign off   = (pos - first) & frame_mask;
  assign hit   = off < win_len;
  assign src   = (pos >= first) ? cur : old;
  assign idx   = IDX_W'(win_len - 1'b1 - off);

  always_comb begin
    bit_o = 1'b0;
    if (hit) bit_o = src[idx];
  end
endmodule

// File: rtl/audio_serial_fmt.sv
module audio_serial_fmt
  import afmt_pkg::*;
#(
  parameter int SAMP_W   = SAMPLE_BITS,
  parameter int NARROW_W = NARROW_BITS,
  parameter int SLOT_S   = SHORT_SLOT,
  parameter int SLOT_L   = LONG_SLOT,
  parameter int DLY_W    = DELAY_BITS,
  localparam int POS_W   = $clog2(2 * SLOT_L),
  localparam int NCH     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_tick,
  input  logic              slot_long,
  input  logic              sample_wide,
  input  logic [DLY_W-1:0]  just_dly,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [SAMP_W-1:0] s_left,
  input  logic [SAMP_W-1:0] s_right,
  output logic              ws,
  output logic              bck,
  output logic              sdo
);
  logic             running, fall_now, frame_end, start, accept;
  logic [POS_W-1:0] pos_nxt, slot_len, frame_mask, eff_dly, win_len;
  logic [SAMP_W-1:0] cur_nxt [NCH];
  logic [SAMP_W-1:0] old_nxt [NCH];
  logic [NCH-1:0]   hit, bits;
  logic             ws_q, sdo_q, sdo_d;
  chan_e            ch_nxt;

  assign start   = ~running & s_valid;
  assign s_ready = ~running | frame_end;
  assign accept  = s_valid & s_ready;

  afmt_timing #(.SLOT_S(SLOT_S), .SLOT_L(SLOT_L)) u_timing (
    .clk(clk), .rst_n(rst_n), .tick(bclk_tick), .start(start),
    .size_long(slot_long), .running(running), .bck(bck),
    .fall_now(fall_now), .frame_end(frame_end), .pos_nxt(pos_nxt),
    .slot_len(slot_len), .frame_mask(frame_mask)
  );

  afmt_sample_hold #(.W(SAMP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(accept), .advance(frame_end),
    .in_l(s_left), .in_r(s_right),
    .cur_l_nxt(cur_nxt[0]), .cur_r_nxt(cur_nxt[1]),
    .old_l_nxt(old_nxt[0]), .old_r_nxt(old_nxt[1])
  );

  assign eff_dly = POS_W'(just_dly) & (slot_len - 1'b1);
  assign win_len = sample_wide ? POS_W'(SAMP_W) : POS_W'(NARROW_W);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    afmt_win #(.W(SAMP_W), .POS_W(POS_W)) u_win (
      .pos(pos_nxt),
      .base(c == 0 ? '0 : slot_len),
      .eff_dly(eff_dly), .win_len(win_len), .frame_mask(frame_mask),
      .cur(cur_nxt[c]), .old(old_nxt[c]),
      .hit(hit[c]), .bit_o(bits[c])
    );
  end

  assign ch_nxt = (pos_nxt >= slot_len) ? CH_RIGHT : CH_LEFT;

  always_comb begin
    if (hit[0])      sdo_d = bits[0];
    else if (hit[1]) sdo_d = bits[1];
    else             sdo_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q  <= 1'b0;
      sdo_q <= 1'b0;
    end else if (start | fall_now) begin
      ws_q  <= (ch_nxt == CH_RIGHT);
      sdo_q <= sdo_d;
    end
  end

  assign ws  = ws_q;
  assign sdo = sdo_q;
endmodule

// File: rtl/audio_serial_fmt_chk.sv
module audio_serial_fmt_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_tick,
  input logic slot_long,
  input logic s_ready,
  input logic ws,
  input logic bck,
  input logic sdo
);
  logic       bck_d, ws_d;
  logic [6:0] falls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d <= 1'b0;
      ws_d  <= 1'b0;
      falls <= '0;
    end else begin
      bck_d <= bck;
      ws_d  <= ws;
      if (ws != ws_d)          falls <= '0;
      else if (bck_d && !bck)  falls <= falls + 1'b1;
    end
  end

  assert_ws_slot_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ws != ws_d) |-> (falls == (slot_long ? 7'd31 : 7'd15)));

  assert_ws_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(bck));

  assert_sdo_stable_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bck) |-> $stable(sdo));

  assert_bck_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bck) |-> $past(bclk_tick));

  assert_ready_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && bck) |-> bclk_tick);
endmodule

bind audio_serial_fmt audio_serial_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .slot_long(slot_long),
  .s_ready(s_ready), .ws(ws), .bck(bck), .sdo(sdo)
);

// File: tb/audio_serial_fmt_tb_top.sv
`timescale 1ns/1ps
module audio_serial_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_tick = 1'b0, slot_long = 1'b0, sample_wide = 1'b0;
  logic [4:0]  just_dly = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [17:0] s_left = '0, s_right = '0;
  logic        ws, bck, sdo;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // behavioural model state
  int m_run, m_bck, m_pos, m_ws, m_sdo;
  int cur_l, cur_r, old_l, old_r;
  int c_slot, c_dly, c_w;
  int src_q [$];

  always #2.5 clk = ~clk;

  audio_serial_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .slot_long(slot_long),
    .sample_wide(sample_wide), .just_dly(just_dly), .s_valid(s_valid),
    .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .ws(ws), .bck(bck), .sdo(sdo)
  );

  function automatic int exp_bit(int pos);
    int p;
    for (int k = 0; k < c_w; k++) begin
      p = c_dly + k;
      if ((p % (2 * c_slot)) == pos)
        return ((p >= 2 * c_slot) ? old_l : cur_l) >> (c_w - 1 - k) & 1;
    end
    for (int k = 0; k < c_w; k++) begin
      p = c_slot + c_dly + k;
      if ((p % (2 * c_slot)) == pos)
        return ((p >= 2 * c_slot) ? old_r : cur_r) >> (c_w - 1 - k) & 1;
    end
    return 0;
  endfunction

  function automatic int exp_ready();
    return (m_run == 0) || (bclk_tick && m_bck == 1 && m_pos == 2 * c_slot - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_bck = 0; m_pos = 0; m_ws = 0; m_sdo = 0;
      cur_l = 0; cur_r = 0; old_l = 0; old_r = 0;
    end else if (m_run == 0) begin
      if (s_valid) begin
        m_run = 1; m_bck = 0; m_pos = 0;
        old_l = cur_l; old_r = cur_r;
        cur_l = src_q[0] & 'h3ffff; cur_r = (src_q[0] >> 7) & 'h3ffff;
        void'(src_q.pop_front());
        m_ws = 0; m_sdo = exp_bit(0);
      end
    end else if (bclk_tick) begin
      if (m_bck == 0) m_bck = 1;
      else begin
        m_bck = 0;
        if (m_pos == 2 * c_slot - 1) begin
          m_pos = 0;
          old_l = cur_l; old_r = cur_r;
          if (s_valid) begin
            cur_l = src_q[0] & 'h3ffff; cur_r = (src_q[0] >> 7) & 'h3ffff;
            void'(src_q.pop_front());
          end
        end else m_pos++;
        m_ws = (m_pos >= c_slot) ? 1 : 0;
        m_sdo = exp_bit(m_pos);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 R2", "ws", int'(ws), m_ws);
    chk("R6", "bck", int'(bck), m_bck);
    chk("R3 R4 R5 R8 R9", "sdo", int'(sdo), m_sdo);
    chk("R7", "s_ready", int'(s_ready), exp_ready());
  endtask

  task automatic run_case(int sz, int dly, int wd, int div, int nsamp, int idle, int ncyc);
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; bclk_tick = 1'b0;
    slot_long = sz[0]; just_dly = dly[4:0]; sample_wide = wd[0];
    c_slot = sz ? 32 : 16; c_dly = dly % c_slot; c_w = wd ? 18 : 16;
    src_q.delete();
    for (int i = 0; i < nsamp; i++) src_q.push_back(int'($urandom & 32'h01ff_ffff));
    repeat (2) @(negedge clk);
    compare_all(); // reset state
    rst_n = 1'b1;
    for (int t = 0; t < ncyc; t++) begin
      @(negedge clk);
      cyc++;
      compare_all();
      bclk_tick = ((t % div) == 0);
      s_valid = (t >= idle) && (src_q.size() > 0);
      if (src_q.size() > 0) begin
        s_left  = 18'(src_q[0]);
        s_right = 18'(src_q[0] >> 7);
      end
    end
  endtask

  initial begin
    run_case(0, 1, 0, 1, 40, 20, 1400);   // R3 R9: I2S, 16-bit slots
    run_case(0, 0, 0, 1, 40, 10, 1400);   // R3: MSB-justified
    run_case(1, 16, 0, 1, 40, 10, 1400);  // R1 R3 R4: 16-bit LSB-justified
    run_case(1, 14, 1, 2, 40, 10, 2600);  // R3: 18-bit LSB-justified
    run_case(1, 1, 1, 3, 3, 30, 4000);    // R6 R8: slow tick, starvation repeats
    run_case(0, 17, 1, 1, 40, 5, 1400);   // R3 R4 R9: delay modulo slot, overlap
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule